// File: doc/BRIEF.md
# Equalizer Coefficient Command Port

This block sits between a codec's verb decoder and a stereo digital equalizer. It accepts 20-bit command words and handles them one per cycle. A word carries either a 4-bit identifier with a 16-bit payload, or a 12-bit identifier with an 8-bit payload. The block keeps a coefficient pointer, two channel banks of equalizer coefficients and a processing-state byte. It returns a 32-bit response one cycle after each command.

Software first selects a processing state that opens coefficient loading. For each coefficient it then writes the pointer and then the value, because the pointer never advances by itself. When symmetric operation is selected, one write fills the same entry in both channel banks, so only one channel's set has to be sent. Two control lines for the filter datapath are derived from the processing state: an enable and a symmetry flag.

Top module: `eq_coef_verbs`

## Requirements
- R1: Identifier 0x5 stores payload bits 7:0 as the coefficient pointer. Identifier 0xD returns the full pointer in response bits 7:0. This includes bit 7, which takes no part in addressing.
- R2: Identifier 0x4 writes payload bits 15:0 at the pointer, and identifier 0xC returns the stored value in response bits 15:0. Pointer bits 5:0 select the entry, bit 6 selects the channel (0 left, 1 right), and bit 7 is ignored.
- R3: No command other than 0x5 changes the pointer. Neither a coefficient write nor a coefficient read advances it.
- R4: Verb 0x703 writes the processing state from payload bits 7:0. Verb 0xF03 returns it in bits 7:0. Accepted values are 0x00, 0x02, 0x80 and 0x82. A request of 0x01 is stored as 0x02, and 0x81 is stored as 0x82. Any other value leaves the state unchanged.
- R5: `eq_enable` is the inverse of state bit 7. `eq_symmetric` is high exactly when state bit 7 is clear.
- R6: After reset the state is 0x00 and the pointer is 0, and both `eq_enable` and `eq_symmetric` are high.
- R7: A coefficient write is carried out only while state bits 1:0 are 00, that is in state 0x00 or 0x80. In any other state it is dropped and no bank changes.
- R8: While `eq_symmetric` is high, a coefficient write lands at the selected entry in both channels, whatever pointer bit 6 holds.
- R9: Verb 0x704 has no effect and verb 0xF04 returns 0. Every other unrecognised word returns 0 and changes nothing.
- R10: `cmd_ready` is always high. Each accepted command produces exactly one `rsp_valid` pulse in the next cycle, and responses to Set commands are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command word present |
| cmd_ready | output | 1 | Command can be taken (always high) |
| cmd_word | input | 20 | Identifier and payload |
| rsp_valid | output | 1 | Response present, one cycle |
| rsp_data | output | 32 | Response word |
| eq_enable | output | 1 | Equalizer active for the datapath |
| eq_symmetric | output | 1 | Both channels share one coefficient set |

## Verification
The bench builds the block with the default parameters: 64 entries per channel, 16-bit coefficients and an 8-bit pointer. With these values the channel bit sits at pointer bit 6 and bit 7 is a spare. Both banks can be written in full within a few hundred cycles, so every entry is loaded and later reads can be checked against known contents. The spare pointer bit makes it possible to show that a stored bit is read back even though it never reaches the banks.

// File: rtl/eq_verb_pkg.sv
package eq_verb_pkg;
  localparam int WORD_W = 20;

  localparam logic [3:0]  ID_SET_COEF  = 4'h4;
  localparam logic [3:0]  ID_SET_PTR   = 4'h5;
  localparam logic [3:0]  ID_GET_COEF  = 4'hC;
  localparam logic [3:0]  ID_GET_PTR   = 4'hD;
  localparam logic [11:0] ID_SET_STATE = 12'h703;
  localparam logic [11:0] ID_GET_STATE = 12'hF03;
  localparam logic [11:0] ID_SET_SDI   = 12'h704;
  localparam logic [11:0] ID_GET_SDI   = 12'hF04;

  typedef enum logic [3:0] {
    OP_NONE,
    OP_SET_PTR,
    OP_GET_PTR,
    OP_SET_COEF,
    OP_GET_COEF,
    OP_SET_STATE,
    OP_GET_STATE,
    OP_SET_SDI,
    OP_GET_SDI
  } eq_op_e;
endpackage

// File: rtl/eq_verb_decode.sv
module eq_verb_decode
  import eq_verb_pkg::*;
(
  input  logic [11:0] ident,
  output eq_op_e      op
);
  always_comb begin
    unique case (ident[11:8])
      ID_SET_COEF: op = OP_SET_COEF;
      ID_SET_PTR:  op = OP_SET_PTR;
      ID_GET_COEF: op = OP_GET_COEF;
      ID_GET_PTR:  op = OP_GET_PTR;
      default: begin
        unique case (ident)
          ID_SET_STATE: op = OP_SET_STATE;
          ID_GET_STATE: op = OP_GET_STATE;
          ID_SET_SDI:   op = OP_SET_SDI;
          ID_GET_SDI:   op = OP_GET_SDI;
          default:      op = OP_NONE;
        endcase
      end
    endcase
  end
endmodule

// File: rtl/eq_proc_state.sv
module eq_proc_state (
  input  logic       clk,
  input  logic       rst,
  input  logic       we,
  input  logic [7:0] wdata,
  output logic [7:0] state,
  output logic       eq_enable,
  output logic       eq_symmetric,
  output logic       load_open
);
  logic       legal;
  logic [7:0] folded;

  // "on" (low bits 01) folds to "benign" (10); 11 and any of bits 6:2 are rejected
  always_comb begin
    legal  = (wdata[6:2] == 5'd0) && (wdata[1:0] != 2'b11);
    folded = {wdata[7], 5'd0, (wdata[1:0] == 2'b01) ? 2'b10 : wdata[1:0]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= 8'h00;
      eq_enable    <= 1'b1;
      eq_symmetric <= 1'b1;
    end else if (we && legal) begin
      state        <= folded;
      eq_enable    <= ~folded[7];
      eq_symmetric <= ~folded[7];
    end
  end

  assign load_open = (state[1:0] == 2'b00);
endmodule

// File: rtl/eq_coef_bank.sv
module eq_coef_bank #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 64,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[addr];
  end
endmodule

// File: rtl/eq_coef_verbs.sv
module eq_coef_verbs
  import eq_verb_pkg::*;
#(
  parameter int COEF_W  = 16,
  parameter int ENTRIES = 64,
  parameter int IDX_W   = 8,
  parameter int RSP_W   = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [WORD_W-1:0] cmd_word,
  output logic              rsp_valid,
  output logic [RSP_W-1:0]  rsp_data,
  output logic              eq_enable,
  output logic              eq_symmetric
);
  localparam int AW     = $clog2(ENTRIES);
  localparam int CH_BIT = AW;
  localparam int NCH    = 2;

  eq_op_e            op;
  logic              accept;
  logic [IDX_W-1:0]  idx_q;
  logic [7:0]        proc_state;
  logic              load_open;
  logic              coef_wr_ok;
  logic              coef_rd;
  logic [COEF_W-1:0] rd_data [NCH];
  logic              rd_sel_q;
  logic              rsp_valid_q;
  logic              rsp_coef_q;
  logic [RSP_W-1:0]  rsp_word_q;

  assign cmd_ready = 1'b1;
  assign accept    = cmd_valid;

  eq_verb_decode u_dec (
    .ident (cmd_word[WORD_W-1:8]),
    .op    (op)
  );

  eq_proc_state u_state (
    .clk          (clk),
    .rst          (rst),
    .we           (accept && op == OP_SET_STATE),
    .wdata        (cmd_word[7:0]),
    .state        (proc_state),
    .eq_enable    (eq_enable),
    .eq_symmetric (eq_symmetric),
    .load_open    (load_open)
  );

  always_ff @(posedge clk) begin
    if (rst) idx_q <= '0;
    else if (accept && op == OP_SET_PTR) idx_q <= cmd_word[IDX_W-1:0];
  end

  assign coef_wr_ok = accept && (op == OP_SET_COEF) && load_open;
  assign coef_rd    = accept && (op == OP_GET_COEF);

  for (genvar ch = 0; ch < NCH; ch++) begin : g_bank
    logic bank_we;
    assign bank_we = coef_wr_ok && (eq_symmetric || (idx_q[CH_BIT] == 1'(ch)));
    eq_coef_bank #(.DATA_W(COEF_W), .DEPTH(ENTRIES)) u_bank (
      .clk   (clk),
      .we    (bank_we),
      .addr  (idx_q[AW-1:0]),
      .wdata (cmd_word[COEF_W-1:0]),
      .re    (coef_rd),
      .rdata (rd_data[ch])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid_q <= 1'b0;
      rsp_coef_q  <= 1'b0;
      rsp_word_q  <= '0;
      rd_sel_q    <= 1'b0;
    end else begin
      rsp_valid_q <= accept;
      rsp_coef_q  <= coef_rd;
      if (coef_rd) rd_sel_q <= idx_q[CH_BIT];
      if (accept && op == OP_GET_PTR)
        rsp_word_q <= {{(RSP_W-IDX_W){1'b0}}, idx_q};
      else if (accept && op == OP_GET_STATE)
        rsp_word_q <= {{(RSP_W-8){1'b0}}, proc_state};
      else
        rsp_word_q <= '0;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_data  = rsp_coef_q ? {{(RSP_W-COEF_W){1'b0}}, rd_data[rd_sel_q]} : rsp_word_q;
endmodule

// File: rtl/eq_coef_verbs_chk.sv
module eq_coef_verbs_chk #(
  parameter int IDX_W = 8,
  parameter int RSP_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic [19:0]      cmd_word,
  input logic             rsp_valid,
  input logic [RSP_W-1:0] rsp_data,
  input logic             eq_enable,
  input logic             eq_symmetric,
  input logic [7:0]       proc_state,
  input logic [IDX_W-1:0] idx_q
);
  logic acc;
  assign acc = cmd_valid && cmd_ready;

  a_r10_rsp_after_accept: assert property (@(posedge clk) disable iff (rst)
    acc |=> rsp_valid);

  a_r10_no_stray_rsp: assert property (@(posedge clk) disable iff (rst)
    !acc |=> !rsp_valid);

  a_r3_ptr_holds: assert property (@(posedge clk) disable iff (rst)
    !(acc && cmd_word[19:16] == 4'h5) |=> $stable(idx_q));

  a_r4_state_folded: assert property (@(posedge clk) disable iff (rst)
    (proc_state[1:0] != 2'b01) && (proc_state[1:0] != 2'b11) && (proc_state[6:2] == 5'd0));

  a_r4_illegal_ignored: assert property (@(posedge clk) disable iff (rst)
    (acc && cmd_word[19:8] == 12'h703 && cmd_word[6:2] != 5'd0) |=> $stable(proc_state));

  a_r5_enable_from_bit7: assert property (@(posedge clk) disable iff (rst)
    (eq_enable != proc_state[7]) && (eq_symmetric != proc_state[7]));

  a_r9_sdi_get_zero: assert property (@(posedge clk) disable iff (rst)
    (acc && cmd_word[19:8] == 12'hF04) |=> (rsp_data == '0));

  a_r6_reset_values: assert property (@(posedge clk)
    rst |=> (proc_state == 8'h00 && idx_q == '0 && eq_enable && eq_symmetric && !rsp_valid));
endmodule

bind eq_coef_verbs eq_coef_verbs_chk #(.IDX_W(IDX_W), .RSP_W(RSP_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .cmd_valid    (cmd_valid),
  .cmd_ready    (cmd_ready),
  .cmd_word     (cmd_word),
  .rsp_valid    (rsp_valid),
  .rsp_data     (rsp_data),
  .eq_enable    (eq_enable),
  .eq_symmetric (eq_symmetric),
  .proc_state   (proc_state),
  .idx_q        (idx_q)
);

// File: tb/eq_coef_verbs_test.sv
module eq_coef_verbs_test;
  localparam int ENTRIES = 64;

  logic        clk = 1'b0;
  logic        rst;
  logic        cmd_valid;
  logic        cmd_ready;
  logic [19:0] cmd_word;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic        eq_enable;
  logic        eq_symmetric;

  always #4 clk = ~clk;

  eq_coef_verbs uut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_word(cmd_word), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .eq_enable(eq_enable), .eq_symmetric(eq_symmetric)
  );

  int checks = 0;
  int failures = 0;
  bit compare_on = 0;
  bit done = 0;

  logic [15:0] ref_mem [2][ENTRIES];
  logic [7:0]  ref_ptr;
  logic [7:0]  ref_state;
  logic        exp_valid;
  logic [31:0] exp_data;
  logic        exp_en;
  logic        exp_sym;
  string       exp_tag;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // compared every clock, 3 ns after the rising edge
  always @(posedge clk) begin
    #3;
    if (compare_on && !done) begin
      check({exp_tag, " R10 rsp_valid"}, 32'(rsp_valid), 32'(exp_valid));
      check("R10 cmd_ready", 32'(cmd_ready), 32'd1);
      if (exp_valid) check({exp_tag, " rsp_data"}, rsp_data, exp_data);
      check({exp_tag, " R5 eq_enable"}, 32'(eq_enable), 32'(exp_en));
      check({exp_tag, " R5 eq_symmetric"}, 32'(eq_symmetric), 32'(exp_sym));
    end
  end

  task automatic send(input logic [19:0] w, input string tag);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_word  = w;
    exp_tag   = tag;
    exp_valid = 1'b1;
    exp_data  = 32'd0;
    if (w[19:16] == 4'h5) ref_ptr = w[7:0];
    else if (w[19:16] == 4'hD) exp_data = {24'd0, ref_ptr};
    else if (w[19:16] == 4'h4) begin
      if (ref_state == 8'h00) begin
        ref_mem[0][ref_ptr[5:0]] = w[15:0];
        ref_mem[1][ref_ptr[5:0]] = w[15:0];
      end else if (ref_state == 8'h80)
        ref_mem[ref_ptr[6]][ref_ptr[5:0]] = w[15:0];
    end
    else if (w[19:16] == 4'hC) exp_data = {16'd0, ref_mem[ref_ptr[6]][ref_ptr[5:0]]};
    else if (w[19:8] == 12'h703) begin
      if (w[7:0] == 8'h00 || w[7:0] == 8'h02 || w[7:0] == 8'h80 || w[7:0] == 8'h82)
        ref_state = w[7:0];
      else if (w[7:0] == 8'h01) ref_state = 8'h02;
      else if (w[7:0] == 8'h81) ref_state = 8'h82;
    end
    else if (w[19:8] == 12'hF03) exp_data = {24'd0, ref_state};
    exp_en  = (ref_state < 8'h80);
    exp_sym = (ref_state < 8'h80);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      cmd_valid = 1'b0;
      cmd_word  = 20'hABCDE;
      exp_valid = 1'b0;
      exp_tag   = "R10 idle";
    end
  endtask

  task automatic set_ptr(input logic [7:0] p, input string tag);
    send({4'h5, 8'h00, p}, tag);
  endtask
  task automatic set_coef(input logic [15:0] v, input string tag);
    send({4'h4, v}, tag);
  endtask
  task automatic get_coef(input string tag);
    send({4'hC, 16'h0000}, tag);
  endtask
  task automatic get_ptr(input string tag);
    send({4'hD, 16'h0000}, tag);
  endtask
  task automatic set_state(input logic [7:0] s, input string tag);
    send({12'h703, s}, tag);
  endtask
  task automatic get_state(input string tag);
    send({12'hF03, 8'h00}, tag);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    cmd_valid = 1'b0;
    cmd_word = 20'h0;
    ref_ptr = 8'h00;
    ref_state = 8'h00;
    exp_valid = 1'b0;
    exp_data = 32'd0;
    exp_en = 1'b1;
    exp_sym = 1'b1;
    exp_tag = "R6 reset";
    repeat (3) @(negedge clk);
    compare_on = 1;
    repeat (2) @(negedge clk);
    rst = 1'b0;

    // R6: state and pointer after reset
    get_state("R6 state after reset");
    get_ptr("R6 pointer after reset");

    // load both banks separately with symmetry off
    set_state(8'h80, "R4 enter 0x80");
    for (int i = 0; i < 2 * ENTRIES; i++) begin
      set_ptr(8'(i), "R1 load pointer");
      set_coef(16'({i[7:0], ~i[7:0]}), "R2 load coef");
    end
    idle(2);

    // R2: read back from both channels
    for (int i = 0; i < 2 * ENTRIES; i += 9) begin
      set_ptr(8'(i), "R1 pointer");
      get_coef("R2 readback");
    end
    // R1/R2: bit 7 kept but not used for addressing
    set_ptr(8'hC5, "R1 pointer spare bit");
    get_ptr("R1 spare bit read back");
    get_coef("R2 spare bit ignored");
    set_ptr(8'h85, "R1 pointer spare bit left");
    get_coef("R2 spare bit ignored left");

    // R3: no auto-increment on write or read
    set_ptr(8'h03, "R3 pointer");
    set_coef(16'h1111, "R3 first write");
    set_coef(16'h2222, "R3 second write same slot");
    get_coef("R3 read same slot");
    get_coef("R3 read again");
    get_ptr("R3 pointer unchanged");
    set_ptr(8'h04, "R3 pointer next");
    get_coef("R3 neighbour untouched");

    // R4/R5: folding and illegal values
    set_state(8'h01, "R4 on folds");
    get_state("R4 read 0x02");
    set_state(8'h81, "R4 on folds off");
    get_state("R4 read 0x82");
    set_state(8'h05, "R4 illegal");
    get_state("R4 illegal ignored");
    set_state(8'h83, "R4 illegal low bits");
    get_state("R4 illegal low ignored");
    set_state(8'h40, "R4 illegal mid bit");
    get_state("R4 illegal mid ignored");

    // R7: writes dropped outside 0x00/0x80
    set_ptr(8'h07, "R7 pointer");
    set_coef(16'hDEAD, "R7 dropped in 0x82");
    get_coef("R7 unchanged in 0x82");
    set_state(8'h02, "R7 to 0x02");
    set_coef(16'hBAD0, "R7 dropped in 0x02");
    get_coef("R7 unchanged in 0x02");
    set_ptr(8'h47, "R7 pointer right");
    get_coef("R7 right unchanged");

    // R8: symmetric writes fill both channels
    set_state(8'h00, "R8 enter 0x00");
    set_ptr(8'h0A, "R8 pointer left");
    set_coef(16'hBEEF, "R8 symmetric write");
    set_ptr(8'h4A, "R8 pointer right");
    get_coef("R8 mirrored to right");
    set_ptr(8'h54, "R8 pointer right 20");
    set_coef(16'hC0DE, "R8 symmetric from right");
    set_ptr(8'h14, "R8 pointer left 20");
    get_coef("R8 mirrored to left");

    // R9: SDI and unknown verbs
    send({12'h704, 8'h3C}, "R9 set SDI");
    send({12'hF04, 8'h00}, "R9 get SDI");
    send({12'h123, 8'h45}, "R9 unknown 12-bit");
    send({4'h2, 16'h0703}, "R9 unknown 4-bit");
    get_state("R9 state unchanged");
    get_ptr("R9 pointer unchanged");
    get_coef("R9 coef unchanged");
    idle(3);

    // R10: gaps between commands
    get_state("R10 after gap");
    idle(1);
    get_ptr("R10 single");
    idle(3);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule